// File: doc/BRIEF.md
# Direct-Mapped Word Cache With Unconditional Write-Through

This block is a direct-mapped cache that sits between a requester issuing 32-bit word reads and writes and a slower word-wide memory. Every slot holds exactly one word. A physical address splits into three parts:

- a tag in the upper bits;
- an index that picks the single slot the word may occupy;
- a two-bit byte offset that word accesses ignore.

Reads look up the slot chosen by the index. A valid slot with a matching tag answers straight from the array. Otherwise the word is fetched from memory, installed in the slot, and returned.

Because a slot holds one whole word, a write needs no lookup. It overwrites the slot's tag and data, marks the slot valid, and is always forwarded to memory. The requester is held off until memory takes the write. Two counters report read hits and read misses. The index width is a parameter: its default of 8 gives 256 slots, and 14 gives the 16K-slot, 64 KB arrangement.

Top module: `word_cache`

## Requirements
- R1: During and after reset all slots are invalid, both counters are zero, `reqReady` is 1, and `memReqValid` and `rspValid` are 0.
- R2: Address bits [INDEX_W+1:2] select the slot and bits [31:INDEX_W+2] form the tag. Bits [1:0] have no effect: a read differing only in those bits from a stored word hits it.
- R3: A read hits when its slot is valid and the stored tag equals the address tag. One cycle after acceptance, `rspValid` is 1 for exactly one cycle with the stored word on `rspData`, and no memory request is raised.
- R4: A read miss raises `memReqValid` with `memReqWrite`=0 and `memReqAddr` equal to the address with bits [1:0] cleared. This happens one cycle after acceptance, and the request is held stable until `memReqReady`. After `memRspValid` is seen, the next cycle carries `rspValid` with `memRspData`.
- R5: A read miss installs the fetched word and its tag in the slot, so a following read of that address hits and returns the fetched word.
- R6: A write stores its tag and data into its slot and marks it valid without any hit check, whatever the slot held. A following read of that address hits and returns the written word.
- R7: A write is sent to memory one cycle after acceptance as `memReqValid`=1, `memReqWrite`=1, with the word-aligned address and data. `reqReady` stays 0 until memory accepts, and a write never raises `rspValid`.
- R8: An address that shares a slot with a different tag evicts the occupant, whether it arrives as a read miss or as a write. A later read of the evicted address misses.
- R9: `hitCount` rises by one per read hit and `missCount` by one per read miss. Writes change neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Requester presents an access |
| reqReady | output | 1 | Block can accept an access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address of the access |
| reqWdata | input | 32 | Write word |
| rspValid | output | 1 | Read data valid, one-cycle pulse |
| rspData | output | 32 | Read data |
| memReqValid | output | 1 | Memory request pending |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | Memory request is a write |
| memReqAddr | output | 32 | Word-aligned memory address |
| memReqWdata | output | 32 | Write-through word |
| memRspValid | input | 1 | Memory read data valid |
| memRspData | input | 32 | Memory read data |
| hitCount | output | 32 | Read hits since reset |
| missCount | output | 32 | Read misses since reset |

## Verification
The directed cases separate the distinct lookup outcomes:

- a cold read, which must miss;
- a repeat read, which must hit;
- a read that varies only the byte offset, which must still hit;
- a write followed by a read, which must hit without a fetch;
- two tags sharing one slot, which must evict;
- the top slot with an all-ones tag, which exposes index and tag slicing faults.

A seeded random phase then draws from a few tags and a few slots. This keeps hits, misses, evictions and overwrites frequent. Memory latency on both handshakes is varied, which tells a block that holds its request properly from one that drops or changes it.

// File: rtl/wcache_pkg.sv
package wcache_pkg;

  typedef struct packed {
    logic capture;     // latch the accepted request
    logic storeReq;    // write request word into its slot
    logic storeFill;   // write fetched word into captured slot
    logic rspFromArr;  // load response register from the array
    logic rspFromMem;  // load response register from memory data
    logic bumpHit;
    logic bumpMiss;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESP,
    ST_MEMRD,
    ST_MEMWAIT,
    ST_MEMWR
  } cacheState_t;

endpackage

// File: rtl/wcache_counter.sv
module wcache_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (bump) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/wcache_control.sv
module wcache_control
  import wcache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         lookupHit,
  input  logic         memReqReady,
  input  logic         memRspValid,
  output ctrlStrobes_t strobes,
  output logic         reqReady,
  output logic         rspValid,
  output logic         memReqValid,
  output logic         memReqWrite
);

  cacheState_t state, stateNext;
  logic accept;

  assign accept = reqValid && (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          strobes.capture = 1'b1;
          if (reqWrite) begin
            strobes.storeReq = 1'b1;
            stateNext        = ST_MEMWR;
          end else if (lookupHit) begin
            strobes.rspFromArr = 1'b1;
            strobes.bumpHit    = 1'b1;
            stateNext          = ST_RESP;
          end else begin
            strobes.bumpMiss = 1'b1;
            stateNext        = ST_MEMRD;
          end
        end
      end
      ST_RESP: stateNext = ST_IDLE;
      ST_MEMRD: begin
        if (memReqReady) stateNext = ST_MEMWAIT;
      end
      ST_MEMWAIT: begin
        if (memRspValid) begin
          strobes.storeFill  = 1'b1;
          strobes.rspFromMem = 1'b1;
          stateNext          = ST_RESP;
        end
      end
      ST_MEMWR: begin
        if (memReqReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady    = (state == ST_IDLE);
  assign rspValid    = (state == ST_RESP);
  assign memReqValid = (state == ST_MEMRD) || (state == ST_MEMWR);
  assign memReqWrite = (state == ST_MEMWR);

endmodule

// File: rtl/wcache_datapath.sv
module wcache_datapath
  import wcache_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 8,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRspData,
  output logic              lookupHit,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWdata,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);

  localparam int OFS_W = $clog2(DATA_W / 8);
  localparam int TAG_W = ADDR_W - INDEX_W - OFS_W;
  localparam int DEPTH = 1 << INDEX_W;

  logic [TAG_W-1:0]  tagArr  [DEPTH];
  logic [DATA_W-1:0] dataArr [DEPTH];
  logic [DEPTH-1:0]  validVec;

  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capWdata;
  logic [DATA_W-1:0] rspDataQ;

  logic [INDEX_W-1:0] inIdx, capIdx, wrIdx;
  logic [TAG_W-1:0]   inTag, capTag, wrTag;
  logic [DATA_W-1:0]  wrData;
  logic               wrEn;

  assign inIdx  = reqAddr[OFS_W +: INDEX_W];
  assign inTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign capIdx = capAddr[OFS_W +: INDEX_W];
  assign capTag = capAddr[ADDR_W-1 -: TAG_W];

  assign lookupHit = validVec[inIdx] && (tagArr[inIdx] == inTag);

  always_comb begin
    wrEn   = strobes.storeReq || strobes.storeFill;
    wrIdx  = strobes.storeFill ? capIdx     : inIdx;
    wrTag  = strobes.storeFill ? capTag     : inTag;
    wrData = strobes.storeFill ? memRspData : reqWdata;
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      tagArr[wrIdx]  <= wrTag;
      dataArr[wrIdx] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
    end else if (wrEn) begin
      validVec[wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capAddr  <= '0;
      capWdata <= '0;
    end else if (strobes.capture) begin
      capAddr  <= reqAddr;
      capWdata <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspDataQ <= '0;
    end else if (strobes.rspFromArr) begin
      rspDataQ <= dataArr[inIdx];
    end else if (strobes.rspFromMem) begin
      rspDataQ <= memRspData;
    end
  end

  assign rspData     = rspDataQ;
  assign memReqAddr  = {capAddr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign memReqWdata = capWdata;

  logic [1:0]       bumpVec;
  logic [CNT_W-1:0] cntOut [2];

  assign bumpVec = {strobes.bumpMiss, strobes.bumpHit};

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    wcache_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .bump (bumpVec[g]),
      .count(cntOut[g])
    );
  end

  assign hitCount  = cntOut[0];
  assign missCount = cntOut[1];

endmodule

// File: rtl/word_cache.sv
module word_cache
  import wcache_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 8,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWdata,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);

  ctrlStrobes_t strobes;
  logic         lookupHit;

  wcache_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .lookupHit  (lookupHit),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .strobes    (strobes),
    .reqReady   (reqReady),
    .rspValid   (rspValid),
    .memReqValid(memReqValid),
    .memReqWrite(memReqWrite)
  );

  wcache_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .INDEX_W(INDEX_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .memRspData (memRspData),
    .lookupHit  (lookupHit),
    .rspData    (rspData),
    .memReqAddr (memReqAddr),
    .memReqWdata(memReqWdata),
    .hitCount   (hitCount),
    .missCount  (missCount)
  );

endmodule

// File: rtl/word_cache_chk.sv
module word_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqWdata,
  input logic              rspValid,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic [DATA_W-1:0] memReqWdata,
  input logic [CNT_W-1:0]  hitCount,
  input logic [CNT_W-1:0]  missCount
);

  // R7
  busy_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  // R4
  memreq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWrite)));

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R7
  wr_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=>
      (memReqValid && memReqWrite && !rspValid &&
       memReqWdata == $past(reqWdata) &&
       memReqAddr == {$past(reqAddr[ADDR_W-1:2]), 2'b00}));

  // R4
  rd_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=>
      (rspValid || (memReqValid && !memReqWrite)));

  // R9
  write_nocount_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=> ($stable(hitCount) && $stable(missCount)));

  // R9
  one_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(hitCount) || $stable(missCount)));

endmodule

bind word_cache word_cache_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqWrite   (reqWrite),
  .reqAddr    (reqAddr),
  .reqWdata   (reqWdata),
  .rspValid   (rspValid),
  .memReqValid(memReqValid),
  .memReqReady(memReqReady),
  .memReqWrite(memReqWrite),
  .memReqAddr (memReqAddr),
  .memReqWdata(memReqWdata),
  .hitCount   (hitCount),
  .missCount  (missCount)
);

// File: tb/word_cache_tb.sv
module word_cache_tb;

  localparam int INDEX_W = 8;
  localparam int DEPTH   = 1 << INDEX_W;
  localparam int TAG_W   = 32 - INDEX_W - 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic        memReqWrite;
  logic [31:0] memReqAddr;
  logic [31:0] memReqWdata;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic [31:0] hitCount;
  logic [31:0] missCount;

  always #4 clk = ~clk;

  word_cache #(.INDEX_W(INDEX_W)) u_dut (.*);

  int total = 0;
  int bad = 0;
  int expHit = 0;
  int expMiss = 0;

  logic [31:0]      shadowMem [logic [31:0]];
  logic             mValid [DEPTH];
  logic [TAG_W-1:0] mTag   [DEPTH];
  logic [31:0]      mData  [DEPTH];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] memValue(input logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    if (shadowMem.exists(w)) return shadowMem[w];
    return (w * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic bit modelHit(input logic [31:0] a);
    int idx = int'(a[INDEX_W+1:2]);
    return mValid[idx] && (mTag[idx] == a[31:INDEX_W+2]);
  endfunction

  task automatic memWait();
    int d = int'($urandom_range(0, 3));
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      check(memReqValid == 1'b1, "R4 request held", 32'(memReqValid), 1);
    end
  endtask

  // Performs one access; expect-hit flag returned for directed checks.
  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                        output bit wasHit);
    int idx = int'(a[INDEX_W+1:2]);
    logic [31:0] alignedA = {a[31:2], 2'b00};
    logic [31:0] expData;
    wasHit = 1'b0;
    @(negedge clk);
    check(reqReady == 1'b1, "R7 ready before access", 32'(reqReady), 1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    if (wr) begin
      check(memReqValid && memReqWrite, "R7 write forwarded", {memReqValid, memReqWrite}, 3);
      check(memReqAddr == alignedA, "R7 write address", memReqAddr, alignedA);
      check(memReqWdata == wd, "R7 write data", memReqWdata, wd);
      check(!rspValid && !reqReady, "R7 no response, stalled", {rspValid, reqReady}, 0);
      memWait();
      memReqReady = 1'b1;
      @(negedge clk);
      memReqReady = 1'b0;
      check(reqReady && !memReqValid && !rspValid, "R7 write done",
            {rspValid, memReqValid, reqReady}, 1);
      shadowMem[alignedA] = wd;
      mValid[idx] = 1'b1; mTag[idx] = a[31:INDEX_W+2]; mData[idx] = wd;
    end else if (modelHit(a)) begin
      wasHit = 1'b1;
      expHit++;
      expData = mData[idx];
      check(rspValid == 1'b1, "R3 hit response", 32'(rspValid), 1);
      check(rspData == expData, "R3 hit data", rspData, expData);
      check(memReqValid == 1'b0, "R3 no fetch on hit", 32'(memReqValid), 0);
      @(negedge clk);
      check(!rspValid && reqReady, "R3 single pulse", {rspValid, reqReady}, 1);
    end else begin
      expMiss++;
      expData = memValue(a);
      check(memReqValid && !memReqWrite, "R4 fetch issued", {memReqValid, memReqWrite}, 2);
      check(memReqAddr == alignedA, "R4 fetch address", memReqAddr, alignedA);
      check(!rspValid, "R4 no early response", 32'(rspValid), 0);
      memWait();
      memReqReady = 1'b1;
      @(negedge clk);
      memReqReady = 1'b0;
      for (int i = 0; i < int'($urandom_range(0, 3)); i++) @(negedge clk);
      check(!rspValid && !reqReady, "R4 waiting for data", {rspValid, reqReady}, 0);
      memRspValid = 1'b1; memRspData = expData;
      @(negedge clk);
      memRspValid = 1'b0; memRspData = '0;
      check(rspValid == 1'b1, "R4 miss response", 32'(rspValid), 1);
      check(rspData == expData, "R4 miss data", rspData, expData);
      @(negedge clk);
      check(!rspValid && reqReady, "R4 single pulse", {rspValid, reqReady}, 1);
      mValid[idx] = 1'b1; mTag[idx] = a[31:INDEX_W+2]; mData[idx] = expData;
    end
    check(hitCount == 32'(expHit), "R9 hit count", hitCount, 32'(expHit));
    check(missCount == 32'(expMiss), "R9 miss count", missCount, 32'(expMiss));
  endtask

  function automatic logic [31:0] mkAddr(input int tag, input int idx, input int ofs);
    logic [31:0] r;
    r = '0;
    r[31:INDEX_W+2] = TAG_W'(tag);
    r[INDEX_W+1:2]  = INDEX_W'(idx);
    r[1:0]          = 2'(ofs);
    return r;
  endfunction

  initial begin
    bit h;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) begin
      mValid[i] = 1'b0; mTag[i] = '0; mData[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1
    check(reqReady && !memReqValid && !rspValid, "R1 reset outputs",
          {rspValid, memReqValid, reqReady}, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(hitCount == 0 && missCount == 0, "R1 counters zero", hitCount | missCount, 0);

    // R1 cold read misses, R5 then hits
    access(1'b0, mkAddr(5, 3, 0), '0, h);
    check(!h, "R1 cold read misses", 32'(h), 0);
    access(1'b0, mkAddr(5, 3, 0), '0, h);
    check(h, "R5 refill hits", 32'(h), 1);
    // R2 offset ignored
    access(1'b0, mkAddr(5, 3, 3), '0, h);
    check(h, "R2 offset ignored", 32'(h), 1);
    // R6 write then read hits without fetch
    access(1'b1, mkAddr(9, 7, 2), 32'hCAFE_F00D, h);
    access(1'b0, mkAddr(9, 7, 1), '0, h);
    check(h, "R6 write installs", 32'(h), 1);
    // R6 write overwrites a different tag; R8 old occupant misses
    access(1'b1, mkAddr(2, 3, 0), 32'h1234_5678, h);
    access(1'b0, mkAddr(5, 3, 0), '0, h);
    check(!h, "R8 evicted by write", 32'(h), 0);
    access(1'b0, mkAddr(2, 3, 0), '0, h);
    check(!h, "R8 evicted by read miss", 32'(h), 0);
    // R2 top slot with all-ones tag
    access(1'b1, 32'hFFFF_FFFF, 32'hA5A5_5A5A, h);
    access(1'b0, 32'hFFFF_FFFC, '0, h);
    check(h, "R2 top slot hit", 32'(h), 1);
    access(1'b0, mkAddr(0, DEPTH - 1, 0), '0, h);
    check(!h, "R8 top slot tag zero misses", 32'(h), 0);

    // random phase
    for (int n = 0; n < 400; n++) begin
      bit wr = ($urandom_range(0, 3) == 0);
      logic [31:0] a = mkAddr(int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
                              int'($urandom_range(0, 3)));
      access(wr, a, $urandom, h);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule